// File: doc/BRIEF.md
# Display RAM Access Controller

This block owns a small display memory of 16 rows by 8 bits and serves it to a host processor over a byte-wide command/data port. A single address counter is shared by data reads and data writes. An auto-increment flag, loaded with each address-setting command, decides whether the counter steps after every display access, and it wraps from the last row back to row 0. The host can protect either half of a row from its writes. It can also force either half of the refresh output to a blank code. That blank code is chosen by the most recent clear command.

A clear command fills every row with the blank code. It writes one row per step, and each step lasts a parameterised number of clock cycles. While the fill runs, a busy flag is visible in the status byte and host data writes are refused. The display refresh logic reads the memory through a separate combinational scan port, which applies the blanking.

Bus timing is synchronous. `wr_en` or `rd_en` is held high for one clock. `a0` high selects command or status, and `a0` low selects data. Read results appear on `rdata` one clock after the read strobe and hold until the next read. When `wr_en` and `rd_en` are high together, the write is taken and the read is ignored.

Top module: `disp_ram_ctrl`

## Requirements
- R1: After reset, every row holds 0x00, the address is 0 with auto-increment off, and no nibble is inhibited or blanked. The blank code is 0x00, busy is 0, `rdata` is 0x00 and the data read source is the non-display source.
- R2: A command whose bits 7:5 are 011 loads the shared address from bits 3:0 and the auto-increment flag from bit 4. It also makes the display RAM the source of data reads.
- R3: A command whose bits 7:5 are 100 loads the same address and auto-increment flag but leaves the data read source unchanged. A command whose bits 7:5 are 010 makes the non-display source current. While that source is selected, data reads return 0x00 and do not move the address.
- R4: A data write (`a0`=0) stores `wdata` at the current address. A data read with the display source selected returns that row on `rdata` one clock later. Either access advances the address by one when auto-increment is set.
- R5: An auto-increment from row 15 wraps the address to row 0, for reads and for writes.
- R6: A command whose bits 7:5 are 101 sets the write inhibits. Bit 3 protects nibble A (data bits 7:4) and bit 2 protects nibble B (data bits 3:0). A protected nibble keeps its old value on a data write, and the address still advances.
- R7: The same command's bit 1 blanks nibble A and bit 0 blanks nibble B. On `scan_data`, a blanked nibble shows the matching nibble of the blank code instead of the stored row. Blanking a whole row needs both bits.
- R8: A command whose bits 7:5 are 110 sets the blank code from bits 4:3: 0x00 when bit 4 is 0, 0x20 for 10, and 0xFF for 11. The code changes only when such a command arrives while not busy.
- R9: A 110 command with bit 2 (display clear) or bit 0 (clear all) set, issued while not busy, raises busy on the next clock. Busy then stays high for exactly 16*ROW_CYCLES clocks while the rows are filled with the blank code, and drops by itself.
- R10: A data write while busy is refused: no row changes and the address does not move. A clear command while busy is ignored.
- R11: A read with `a0`=1 returns the status byte one clock later: busy in bit 7 and zeros below. It does not move the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-clock write strobe |
| rd_en | input | 1 | One-clock read strobe |
| a0 | input | 1 | 1 = command/status, 0 = data |
| wdata | input | 8 | Write data or command byte |
| rdata | output | 8 | Read result, valid one clock after `rd_en` |
| busy | output | 1 | High while a clear fill is running |
| scan_row | input | 4 | Row requested by the refresh logic |
| scan_data | output | 8 | Blanked contents of `scan_row` |

## Verification
The hardest case to reach is a host write that lands during a clear. It needs a clear to be started and then data writes, status reads and a second clear command to arrive inside the fill window. The stimulus issues a clear and then, without waiting, sends each of these while busy is high. Address wrap in both directions is reached by a sixteen-plus-one write burst and a read burst that starts at row 14. The bench model follows every row, the address and the busy window cycle by cycle and is compared on every clock.

// File: rtl/disp_ram_ctrl.sv
module disp_ram_ctrl #(
  parameter int AW = 4,
  parameter int DW = 8,
  parameter int ROW_CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          a0,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          busy,
  input  logic [AW-1:0] scan_row,
  output logic [DW-1:0] scan_data
);
  localparam int ROWS = 1 << AW;
  localparam int NW = DW / 2;
  localparam int TW = (ROW_CYCLES > 1) ? $clog2(ROW_CYCLES) : 1;

  logic [DW-1:0] mem [ROWS];
  logic [AW-1:0] addr, crow;
  logic [TW-1:0] tick;
  logic [DW-1:0] code;
  logic ai, src_disp, inh_a, inh_b, blk_a, blk_b;

  wire [2:0] op      = wdata[7:5];
  wire       cmd_wr  = wr_en & a0;
  wire       wr_ok   = wr_en & ~a0 & ~busy;
  wire       dat_rd  = rd_en & ~wr_en & ~a0;
  wire       st_rd   = rd_en & ~wr_en & a0;
  wire       set_adr = cmd_wr & (op == 3'b011 || op == 3'b100);
  wire       clr_cmd = cmd_wr & (op == 3'b110) & ~busy;
  wire       clr_go  = clr_cmd & (wdata[2] | wdata[0]);
  wire       step_end = busy & (tick == TW'(ROW_CYCLES - 1));
  wire       adv     = ai & (wr_ok | (dat_rd & src_disp));
  wire [DW-1:0] wmask = {{NW{~inh_a}}, {NW{~inh_b}}};
  wire [DW-1:0] new_code = !wdata[4] ? '0 : (wdata[3] ? '1 : DW'(8'h20));
  wire unused_ok = &{1'b0, wdata[1]};

  assign scan_data = {blk_a ? code[DW-1:NW] : mem[scan_row][DW-1:NW],
                      blk_b ? code[NW-1:0]  : mem[scan_row][NW-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0; ai <= 1'b0; src_disp <= 1'b0;
      inh_a <= 1'b0; inh_b <= 1'b0; blk_a <= 1'b0; blk_b <= 1'b0;
      code <= '0; rdata <= '0;
    end else begin
      if (set_adr) begin
        addr <= wdata[AW-1:0];
        ai   <= wdata[4];
      end else if (adv) begin
        addr <= addr + 1'b1;
      end
      if (cmd_wr && op == 3'b011) src_disp <= 1'b1;
      if (cmd_wr && op == 3'b010) src_disp <= 1'b0;
      if (cmd_wr && op == 3'b101) begin
        inh_a <= wdata[3]; inh_b <= wdata[2];
        blk_a <= wdata[1]; blk_b <= wdata[0];
      end
      if (clr_cmd) code <= new_code;
      if (dat_rd) rdata <= src_disp ? mem[addr] : '0;
      else if (st_rd) rdata <= {busy, {(DW-1){1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; crow <= '0; tick <= '0;
    end else if (clr_go) begin
      busy <= 1'b1; crow <= '0; tick <= '0;
    end else if (step_end) begin
      tick <= '0;
      if (crow == AW'(ROWS - 1)) busy <= 1'b0;
      else crow <= crow + 1'b1;
    end else if (busy) begin
      tick <= tick + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ROWS; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[addr] <= (mem[addr] & ~wmask) | (wdata & wmask);
    end else if (step_end) begin
      mem[crow] <= code;
    end
  end

  a_r10_refused_write_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && !a0) |=> addr == $past(addr));
  a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && ai && addr == AW'(ROWS - 1)) |=> addr == '0);
  a_r6_inhibit_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && inh_a) |=> mem[$past(addr)][DW-1:NW] == $past(mem[addr][DW-1:NW]));
  a_r9_fill_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (mem[ROWS-1] == code && mem[0] == code));
  a_r11_status_bit: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |=> rdata == {$past(busy), {(DW-1){1'b0}}});
endmodule

// File: tb/disp_ram_ctrl_test.sv
`timescale 1ns/1ps
module disp_ram_ctrl_test;
  localparam int RC = 4;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, a0 = 0;
  logic [7:0] wdata = 0, rdata, scan_data;
  logic busy;
  logic [3:0] scan_row = 0;
  int checks = 0, fails = 0, cyc = 0;
  string phase = "R1";

  disp_ram_ctrl #(.AW(4), .DW(8), .ROW_CYCLES(RC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .a0(a0),
    .wdata(wdata), .rdata(rdata), .busy(busy), .scan_row(scan_row),
    .scan_data(scan_data));

  always #4 clk = ~clk;

  int m[16];
  int addr = 0, ai = 0, src = 0, ia = 0, ib = 0, ba = 0, bb = 0;
  int code = 0, bsy = 0, e = 0, rd = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m[i]) m[i] = 0;
      addr = 0; ai = 0; src = 0; ia = 0; ib = 0; ba = 0; bb = 0;
      code = 0; bsy = 0; e = 0; rd = 0;
    end else begin
      int ob, w, nv;
      ob = bsy; w = wdata;
      if (wr_en) begin
        if (a0) begin
          case (w >> 5)
            3: begin addr = w % 16; ai = (w >> 4) % 2; src = 1; end
            2: src = 0;
            4: begin addr = w % 16; ai = (w >> 4) % 2; end
            5: begin ia = (w >> 3) % 2; ib = (w >> 2) % 2; ba = (w >> 1) % 2; bb = w % 2; end
            6: if (!ob) begin
                 code = ((w >> 4) % 2 == 0) ? 0 : (((w >> 3) % 2) ? 255 : 32);
                 if ((w >> 2) % 2 || w % 2) begin bsy = 1; e = 0; end
               end
            default: ;
          endcase
        end else if (!ob) begin
          nv = ((ia ? m[addr] : w) / 16) * 16 + ((ib ? m[addr] : w) % 16);
          m[addr] = nv;
          if (ai) addr = (addr + 1) % 16;
        end
      end else if (rd_en) begin
        if (a0) rd = ob * 128;
        else if (src) begin rd = m[addr]; if (ai) addr = (addr + 1) % 16; end
        else rd = 0;
      end
      if (ob) begin
        if (e % RC == RC - 1) m[e / RC] = code;
        if (e == 16 * RC - 1) bsy = 0;
        e++;
      end
    end
  end

  always @(negedge clk) if (cyc > 0) begin
    int hi, lo, exp_s;
    hi = ba ? code / 16 : m[scan_row] / 16;
    lo = bb ? code % 16 : m[scan_row] % 16;
    exp_s = hi * 16 + lo;
    checks += 3;
    if (rdata !== 8'(rd)) begin fails++; $display("FAIL %s rdata act=%h exp=%h", phase, rdata, rd); end
    if (busy !== 1'(bsy)) begin fails++; $display("FAIL %s busy act=%b exp=%0d", phase, busy, bsy); end
    if (scan_data !== 8'(exp_s)) begin fails++; $display("FAIL %s scan row %0d act=%h exp=%h", phase, scan_row, scan_data, exp_s); end
  end

  always @(posedge clk) begin
    cyc++;
    #2 scan_row <= scan_row + 1;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog act=%0d cycles exp=finish", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic op(input logic w, input logic a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = w; rd_en = !w; a0 = a; wdata = d;
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask
  task automatic cmd(input logic [7:0] d); op(1, 1, d); endtask
  task automatic dwr(input logic [7:0] d); op(1, 0, d); endtask
  task automatic drd(); op(0, 0, 8'h00); endtask
  task automatic srd(); op(0, 1, 8'h00); endtask
  task automatic idle(input int n); repeat (n) @(posedge clk); endtask

  initial begin
    phase = "R1";
    idle(3); #1 rst_n = 1;
    idle(20);
    drd();
    phase = "R2";
    cmd(8'h70);
    drd();
    phase = "R4";
    cmd(8'h90);
    for (int i = 0; i < 17; i++) dwr(8'(i * 17 + 5));
    cmd(8'h73);
    for (int i = 0; i < 3; i++) drd();
    phase = "R5";
    cmd(8'h7E);
    for (int i = 0; i < 4; i++) drd();
    phase = "R3";
    cmd(8'h85); dwr(8'hAB); dwr(8'hCD); drd(); drd();
    cmd(8'h40); drd();
    cmd(8'h82); drd(); drd();
    cmd(8'h62); drd();
    phase = "R6";
    cmd(8'hA8); cmd(8'h82); dwr(8'h3C);
    cmd(8'hA4); cmd(8'h93); dwr(8'h96); dwr(8'h11);
    cmd(8'hAC); dwr(8'hFF);
    cmd(8'hA0); cmd(8'h72); for (int i = 0; i < 4; i++) drd();
    phase = "R7";
    cmd(8'hA3); idle(18);
    cmd(8'hD8); cmd(8'hA2); idle(18);
    cmd(8'hA1); idle(18);
    phase = "R8";
    cmd(8'hD0); cmd(8'hA3); idle(18);
    cmd(8'hD8); idle(18);
    cmd(8'hC0); idle(18);
    phase = "R9";
    cmd(8'hD4); srd();
    phase = "R10";
    cmd(8'h97); dwr(8'h55); dwr(8'h66); cmd(8'hC4); srd();
    phase = "R11";
    srd(); drd(); idle(80); srd();
    phase = "R9";
    cmd(8'hA0); cmd(8'h70); for (int i = 0; i < 16; i++) drd();
    cmd(8'hD1); idle(40); srd(); idle(40); srd();
    cmd(8'h70); for (int i = 0; i < 16; i++) drd();
    cmd(8'hC5); idle(70); cmd(8'h90); dwr(8'h12); dwr(8'h34); cmd(8'h60); drd(); drd();
    idle(5);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule